// File: doc/BRIEF.md
# Linked-Descriptor DMA Walker

This block is a single-channel DMA engine that walks a chain of descriptors kept in shared memory. Each descriptor is four 32-bit words at a 16-byte-aligned address. Word 0 is frame control, word 1 is flags and status, word 2 is the buffer address, and word 3 is the link to the next descriptor. Software builds the chain and hands each descriptor to hardware by setting its ownership bit. It then writes the address of the first descriptor and sets the start bit.

The engine reads each descriptor over a single word-wide memory port. If hardware owns the descriptor, the engine reads the buffer one word at a time and presents each word on an output stream. It then writes frame control back with ownership returned to software and the error and count fields filled in, and follows the link. First and last markers group descriptors into frames. When the last descriptor of a frame completes, the engine stores in that descriptor the number of descriptors the frame used.

Software reaches the engine through four registers on a small register port: control, write-one-to-clear status, first-descriptor address, and read-only current-descriptor address. A single interrupt line is raised from the status bits that software has enabled.

Top module: `desc_chain_dma`

## Requirements
- R1: After reset `busy`, `irq` and `mem_req` are 0, and the status register (reg_addr 1) reads 0.
- R2: A control write (reg_addr 0) with bit 31 set loads the current descriptor from the first-descriptor register (reg_addr 2, byte address, low 4 bits ignored). While bit 29 (chain) is set, the engine follows the links in order. Each hardware-owned descriptor sends exactly frame-control bits 15:0 buffer words on `out_data`, in buffer order. `out_last` marks the final word of a descriptor whose link bits 1:0 mark it last (01 or 11).
- R3: Link bit 2 chooses the buffer direction. With 0 the address steps up by 4 per word; with 1 it steps down by 4.
- R4: Every processed descriptor has frame control written back with bit 31 (ownership) cleared, and this write comes after its last buffer word. On a successful last descriptor, bits 21:16 receive the number of descriptors in the frame. On other descriptors those bits keep their fetched value.
- R5: A fetched descriptor with frame-control bit 31 at 0 makes the engine stop and leaves its memory unmodified. The engine sets status bit 4 and keeps that descriptor as current. A control write with bit 30 set resumes from it.
- R6: A descriptor with buffer size 0 transfers no data and is still written back.
- R7: Status bit 0 (end of frame) is set only when a last descriptor completes without error and its link bit 3 is set. Status bit 1 is set on every descriptor write-back.
- R8: Status bits clear when a 1 is written to them at reg_addr 1. `irq` is the OR of status bits 4:0 ANDed with control bits 18:14 respectively.
- R9: Link position 2'b10 or 2'b11 marks a frame's first descriptor. A first marker while a frame is open, or a non-first marker while none is open, is a protocol error. The engine then moves no data, writes back with bit 29 set, sets status bit 2 and stops.
- R10: An error response on a buffer read is a data error. The failing word is not emitted, and the descriptor is written back with bit 30 set. The engine sets status bit 3 and stops.
- R11: With control bit 29 clear, the engine stops after one descriptor, sets status bit 4 and leaves the current descriptor unchanged.
- R12: reg_addr 3 reads the byte address of the descriptor being processed or last stopped at. It does not change while the engine is idle and no start or continue is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 first, 3 current |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt, OR of enabled status bits |
| busy | output | 1 | Engine is walking the chain |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Error response with `mem_ack` |
| out_valid | output | 1 | Buffer word valid |
| out_data | output | 32 | Buffer word |
| out_last | output | 1 | Final word of a frame's last descriptor |

## Verification
The bench builds the engine with its default frame-count width of 6. Its frames reach three descriptors, so the written-back counts 1 and 3 are observed in memory. The bench memory acknowledges every request in the same cycle and returns an error for the top quarter of its 1 KiB space. With that memory the bench can drive a full frame, a stall on a software-owned descriptor followed by a continue, a descending buffer, and a zero-length descriptor. Its byte placement also triggers the position error and the bus error on demand.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  localparam int WORD_W  = 32;
  localparam int SIZE_W  = 16;
  localparam int CNTF_W  = 6;
  localparam int ST_W    = 5;
  localparam int DADDR_W = WORD_W - 4;

  localparam logic [1:0] RA_CTRL  = 2'd0;
  localparam logic [1:0] RA_STAT  = 2'd1;
  localparam logic [1:0] RA_FIRST = 2'd2;
  localparam logic [1:0] RA_CUR   = 2'd3;

  localparam int ST_EOF  = 0;
  localparam int ST_EOD  = 1;
  localparam int ST_PERR = 2;
  localparam int ST_DERR = 3;
  localparam int ST_FIN  = 4;

  localparam int C_START = 31;
  localparam int C_CONT  = 30;
  localparam int C_CHAIN = 29;
  localparam int C_IE_LO = 14;

  localparam int LK_LAST  = 0;
  localparam int LK_FIRST = 1;
  localparam int LK_DEC   = 2;
  localparam int LK_EOFIE = 3;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER, S_WB} seq_state_e;
endpackage

// File: rtl/dmaw_regs.sv
module dmaw_regs
  import dmaw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  input  logic [DADDR_W-1:0] cur_i,
  input  logic [ST_W-1:0]    set_i,
  output logic [WORD_W-1:0]  reg_rdata,
  output logic               go_start_o,
  output logic               go_cont_o,
  output logic               chain_o,
  output logic [DADDR_W-1:0] first_o,
  output logic               irq_o
);
  logic [ST_W-1:0]    ie_q, ie_n, st_q, st_n;
  logic               chain_q, chain_n;
  logic [DADDR_W-1:0] first_q, first_n;
  logic               wr_ctrl, wr_stat, wr_first;

  assign wr_ctrl  = reg_we && (reg_addr == RA_CTRL);
  assign wr_stat  = reg_we && (reg_addr == RA_STAT);
  assign wr_first = reg_we && (reg_addr == RA_FIRST);

  always_comb begin
    ie_n    = ie_q;
    chain_n = chain_q;
    first_n = first_q;
    if (wr_ctrl) begin
      ie_n    = reg_wdata[C_IE_LO +: ST_W];
      chain_n = reg_wdata[C_CHAIN];
    end
    if (wr_first) first_n = reg_wdata[WORD_W-1:4];
    st_n = (st_q & ~(wr_stat ? reg_wdata[ST_W-1:0] : '0)) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q    <= '0;
      chain_q <= 1'b0;
      first_q <= '0;
      st_q    <= '0;
    end else begin
      ie_q    <= ie_n;
      chain_q <= chain_n;
      first_q <= first_n;
      st_q    <= st_n;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL:  reg_rdata = {2'b00, chain_q, 10'd0, ie_q, 14'd0};
      RA_STAT:  reg_rdata = {{(WORD_W-ST_W){1'b0}}, st_q};
      RA_FIRST: reg_rdata = {first_q, 4'h0};
      default:  reg_rdata = {cur_i, 4'h0};
    endcase
  end

  assign go_start_o = wr_ctrl && reg_wdata[C_START];
  assign go_cont_o  = wr_ctrl && reg_wdata[C_CONT];
  assign chain_o    = chain_q;
  assign first_o    = first_q;
  assign irq_o      = |(st_q & ie_q);

  // R8: a written one clears the bit unless hardware sets it in the same cycle
  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[ST_EOD] && !set_i[ST_EOD]) |=> !st_q[ST_EOD]);
endmodule

// File: rtl/dmaw_frame.sv
module dmaw_frame #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             chk_i,
  input  logic             first_i,
  input  logic             close_i,
  output logic             pos_err_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             open_q, open_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  assign pos_err_o = chk_i && (first_i == open_q);

  always_comb begin
    open_n = open_q;
    cnt_n  = cnt_q;
    if (clr_i) begin
      open_n = 1'b0;
      cnt_n  = '0;
    end else if (chk_i && !pos_err_o) begin
      open_n = 1'b1;
      cnt_n  = first_i ? CNT_W'(1) : cnt_q + CNT_W'(1);
    end else if (close_i) begin
      open_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      open_q <= open_n;
      cnt_q  <= cnt_n;
    end
  end

  assign cnt_o = cnt_q;

  // R9: an accepted first marker leaves a frame open with a count of one
  a_r9_first_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_i && first_i && !pos_err_o && !clr_i) |=> (open_q && cnt_q == CNT_W'(1)));
endmodule

// File: rtl/dmaw_seq.sv
module dmaw_seq
  import dmaw_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_start_i,
  input  logic               go_cont_i,
  input  logic               chain_i,
  input  logic [DADDR_W-1:0] first_i,
  output logic [DADDR_W-1:0] cur_o,
  output logic               busy_o,
  output logic [ST_W-1:0]    set_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [WORD_W-1:0]  mem_addr_o,
  output logic [WORD_W-1:0]  mem_wdata_o,
  input  logic               mem_ack_i,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  input  logic               mem_err_i,
  output logic               out_valid_o,
  output logic [WORD_W-1:0]  out_data_o,
  output logic               out_last_o,
  output logic               fr_clr_o,
  output logic               fr_chk_o,
  output logic               fr_first_o,
  output logic               fr_close_o,
  input  logic               fr_pos_err_i,
  input  logic [CNT_W-1:0]   fr_cnt_i
);
  seq_state_e         state_q, state_n;
  logic [1:0]         widx_q, widx_n;
  logic [DADDR_W-1:0] cur_q, cur_n, nxt_q, nxt_n;
  logic [28:0]        fc_q, fc_n;
  logic               dec_q, dec_n, eofie_q, eofie_n, last_q, last_n;
  logic               perr_q, perr_n, derr_q, derr_n;
  logic [WORD_W-1:0]  baddr_q, baddr_n;
  logic [SIZE_W-1:0]  left_q, left_n;
  logic [CNTF_W-1:0]  cnt_field;
  logic               ok_last;

  assign ok_last   = last_q && !perr_q && !derr_q;
  assign cnt_field = ok_last ? CNTF_W'(fr_cnt_i) : fc_q[21:16];

  always_comb begin
    state_n = state_q;  widx_n = widx_q;   cur_n  = cur_q;   nxt_n = nxt_q;
    fc_n    = fc_q;     dec_n  = dec_q;    eofie_n = eofie_q; last_n = last_q;
    perr_n  = perr_q;   derr_n = derr_q;   baddr_n = baddr_q; left_n = left_q;
    set_o = '0;  mem_req_o = 1'b0;  mem_we_o = 1'b0;
    mem_addr_o = '0;  mem_wdata_o = '0;  out_valid_o = 1'b0;
    fr_clr_o = 1'b0;  fr_chk_o = 1'b0;  fr_first_o = 1'b0;  fr_close_o = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (go_start_i) begin
          fr_clr_o = 1'b1;
          cur_n    = first_i;
          state_n  = S_FETCH;
          widx_n   = 2'd0;
        end else if (go_cont_i) begin
          state_n = S_FETCH;
          widx_n  = 2'd0;
        end
      end
      S_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {cur_q, 4'h0} + {{(WORD_W-4){1'b0}}, widx_q, 2'b00};
        if (mem_ack_i) begin
          widx_n = widx_q + 2'd1;
          case (widx_q)
            2'd0: begin
              fc_n   = mem_rdata_i[28:0];
              perr_n = 1'b0;
              derr_n = 1'b0;
              if (!mem_rdata_i[31]) begin
                state_n       = S_IDLE;
                set_o[ST_FIN] = 1'b1;
              end
            end
            2'd2: baddr_n = mem_rdata_i;
            2'd3: begin
              nxt_n      = mem_rdata_i[WORD_W-1:4];
              dec_n      = mem_rdata_i[LK_DEC];
              eofie_n    = mem_rdata_i[LK_EOFIE];
              last_n     = mem_rdata_i[LK_LAST];
              fr_chk_o   = 1'b1;
              fr_first_o = mem_rdata_i[LK_FIRST];
              left_n     = fc_q[SIZE_W-1:0];
              if (fr_pos_err_i) begin
                perr_n  = 1'b1;
                state_n = S_WB;
              end else if (fc_q[SIZE_W-1:0] == '0) begin
                state_n = S_WB;
              end else begin
                state_n = S_XFER;
              end
            end
            default: ;
          endcase
        end
      end
      S_XFER: begin
        mem_req_o  = 1'b1;
        mem_addr_o = baddr_q;
        if (mem_ack_i) begin
          if (mem_err_i) begin
            derr_n  = 1'b1;
            state_n = S_WB;
          end else begin
            out_valid_o = 1'b1;
            baddr_n = dec_q ? baddr_q - WORD_W'(4) : baddr_q + WORD_W'(4);
            left_n  = left_q - SIZE_W'(1);
            if (left_q == SIZE_W'(1)) state_n = S_WB;
          end
        end
      end
      default: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {cur_q, 4'h0};
        mem_wdata_o = {1'b0, derr_q, perr_q, fc_q[28:22], cnt_field, fc_q[15:0]};
        if (mem_ack_i) begin
          set_o[ST_EOD]  = 1'b1;
          set_o[ST_EOF]  = ok_last && eofie_q;
          set_o[ST_PERR] = perr_q;
          set_o[ST_DERR] = derr_q;
          fr_close_o     = last_q || perr_q || derr_q;
          if (perr_q || derr_q) begin
            state_n = S_IDLE;
          end else if (!chain_i) begin
            state_n       = S_IDLE;
            set_o[ST_FIN] = 1'b1;
          end else begin
            cur_n   = nxt_q;
            state_n = S_FETCH;
            widx_n  = 2'd0;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;  widx_q <= '0;  cur_q <= '0;  nxt_q <= '0;
      fc_q <= '0;  dec_q <= 1'b0;  eofie_q <= 1'b0;  last_q <= 1'b0;
      perr_q <= 1'b0;  derr_q <= 1'b0;  baddr_q <= '0;  left_q <= '0;
    end else begin
      state_q <= state_n;  widx_q <= widx_n;  cur_q <= cur_n;  nxt_q <= nxt_n;
      fc_q <= fc_n;  dec_q <= dec_n;  eofie_q <= eofie_n;  last_q <= last_n;
      perr_q <= perr_n;  derr_q <= derr_n;  baddr_q <= baddr_n;  left_q <= left_n;
    end
  end

  assign cur_o      = cur_q;
  assign busy_o     = (state_q != S_IDLE);
  assign out_data_o = mem_rdata_i;
  assign out_last_o = out_valid_o && (left_q == SIZE_W'(1)) && last_q;

  // R4: every descriptor write returns ownership to software
  a_r4_wb_clears_own: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> !mem_wdata_o[31]);
  // R5: a software-owned descriptor stops the engine at once
  a_r5_halt_on_sw_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FETCH && widx_q == 2'd0 && mem_ack_i && !mem_rdata_i[31]) |=> !busy_o);
  // R6: a zero-length descriptor never enters the transfer phase
  a_r6_zero_size_skips: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FETCH && widx_q == 2'd3 && mem_ack_i && fc_q[SIZE_W-1:0] == '0)
      |=> state_q != S_XFER);
  // R12: current descriptor holds while idle and not kicked
  a_r12_cur_stable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !go_start_i && !go_cont_i) |=> $stable(cur_o));
endmodule

// File: rtl/desc_chain_dma.sv
module desc_chain_dma
  import dmaw_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err,
  output logic        out_valid,
  output logic [31:0] out_data,
  output logic        out_last
);
  logic               go_start, go_cont, chain;
  logic [DADDR_W-1:0] first_addr, cur_addr;
  logic [ST_W-1:0]    st_set;
  logic               fr_clr, fr_chk, fr_first, fr_close, fr_pos_err;
  logic [CNT_W-1:0]   fr_cnt;

  dmaw_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cur_i(cur_addr), .set_i(st_set),
    .reg_rdata(reg_rdata), .go_start_o(go_start), .go_cont_o(go_cont),
    .chain_o(chain), .first_o(first_addr), .irq_o(irq)
  );

  dmaw_frame #(.CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .clr_i(fr_clr), .chk_i(fr_chk),
    .first_i(fr_first), .close_i(fr_close),
    .pos_err_o(fr_pos_err), .cnt_o(fr_cnt)
  );

  dmaw_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_start_i(go_start), .go_cont_i(go_cont),
    .chain_i(chain), .first_i(first_addr), .cur_o(cur_addr), .busy_o(busy),
    .set_o(st_set), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .mem_err_i(mem_err), .out_valid_o(out_valid),
    .out_data_o(out_data), .out_last_o(out_last), .fr_clr_o(fr_clr),
    .fr_chk_o(fr_chk), .fr_first_o(fr_first), .fr_close_o(fr_close),
    .fr_pos_err_i(fr_pos_err), .fr_cnt_i(fr_cnt)
  );

  // R1: no memory traffic while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
endmodule

// File: tb/desc_chain_dma_tb_top.sv
module desc_chain_dma_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, busy, mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        out_valid, out_last;
  logic [31:0] out_data;

  logic [31:0] mem [0:255];
  logic [31:0] cap [0:15];
  int ncap, nlast, last_at;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  desc_chain_dma dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last)
  );

  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[9:2]];
  assign mem_err   = mem_req && !mem_we && (mem_addr[9:8] == 2'b11);

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (out_valid) begin
      if (ncap < 16) cap[ncap] = out_data;
      if (out_last) begin nlast = nlast + 1; last_at = ncap; end
      ncap = ncap + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 500) begin @(negedge clk); n++; end
    check({req, " engine idle"}, {31'd0, busy}, 32'd0);
  endtask

  task automatic put_desc(input int a, input logic [31:0] fc, input logic [31:0] b,
                          input logic [31:0] lk);
    mem[a/4] = fc; mem[a/4+1] = 32'd0; mem[a/4+2] = b; mem[a/4+3] = lk;
  endtask

  task automatic clear_cap();
    ncap = 0; nlast = 0; last_at = -1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 mem_req", {31'd0, mem_req}, 32'd0);
    reg_rd(2'd1, d); check("R1 status", d, 32'd0);
  endtask

  task automatic t_frame();
    logic [31:0] d;
    put_desc('h00, 32'h8000_0002, 32'h100, 32'h12);
    put_desc('h10, 32'h8000_0003, 32'h140, 32'h20);
    put_desc('h20, 32'h8000_0001, 32'h180, 32'h39);
    mem['h30/4] = 32'h0;
    clear_cap();
    reg_wr(2'd2, 32'h0);
    reg_wr(2'd0, (32'h1 << 31) | (32'h1 << 29) | (32'h1F << 14));
    wait_idle("R2");
    check("R2 word count", ncap, 6);
    check("R2 word0", cap[0], 32'hA500_0040);
    check("R2 word1", cap[1], 32'hA500_0041);
    check("R2 word2", cap[2], 32'hA500_0050);
    check("R2 word4", cap[4], 32'hA500_0052);
    check("R2 word5", cap[5], 32'hA500_0060);
    check("R2 out_last once", nlast, 1);
    check("R2 out_last position", last_at, 5);
    check("R4 first desc wb", mem[0], 32'h0000_0002);
    check("R4 middle desc wb", mem[4], 32'h0000_0003);
    check("R4 last desc count", mem[8], 32'h0003_0001);
    check("R5 sw-owned untouched", mem['h30/4], 32'h0);
    reg_rd(2'd1, d); check("R7 status eof eod fin", d, 32'h13);
    reg_rd(2'd3, d); check("R12 current at stall", d, 32'h30);
    check("R8 irq enabled", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_continue_zero();
    logic [31:0] d;
    put_desc('h30, 32'h8000_0000, 32'h100, 32'h43);
    mem['h40/4] = 32'h0;
    reg_wr(2'd1, 32'h1F);
    reg_rd(2'd1, d); check("R8 w1c status", d, 32'h0);
    check("R8 irq after clear", {31'd0, irq}, 32'd0);
    clear_cap();
    reg_wr(2'd0, (32'h1 << 30) | (32'h1 << 29) | (32'h1 << 14));
    wait_idle("R5");
    check("R6 no words", ncap, 0);
    check("R6 zero-size wb count", mem['h30/4], 32'h0001_0000);
    reg_rd(2'd1, d); check("R7 no eof without enable", d, 32'h12);
    check("R8 irq masked", {31'd0, irq}, 32'd0);
    reg_rd(2'd3, d); check("R5 continue advanced", d, 32'h40);
    reg_wr(2'd0, 32'h1 << 18);
    check("R8 irq fin enabled", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_decrement();
    logic [31:0] d;
    reg_wr(2'd1, 32'h1F);
    put_desc('h50, 32'h8000_0003, 32'h1C8, 32'h7);
    clear_cap();
    reg_wr(2'd2, 32'h50);
    reg_wr(2'd0, 32'h1 << 31);
    wait_idle("R11");
    check("R3 word count", ncap, 3);
    check("R3 word0", cap[0], 32'hA500_0072);
    check("R3 word1", cap[1], 32'hA500_0071);
    check("R3 word2", cap[2], 32'hA500_0070);
    check("R4 single wb", mem['h50/4], 32'h0001_0003);
    reg_rd(2'd1, d); check("R11 status eod fin", d, 32'h12);
    reg_rd(2'd3, d); check("R11 current kept", d, 32'h50);
  endtask

  task automatic t_proto_err();
    logic [31:0] d;
    reg_wr(2'd1, 32'h1F);
    put_desc('h60, 32'h8000_0004, 32'h100, 32'h0);
    clear_cap();
    reg_wr(2'd2, 32'h60);
    reg_wr(2'd0, (32'h1 << 31) | (32'h1 << 29) | (32'h1 << 16));
    wait_idle("R9");
    check("R9 no words", ncap, 0);
    check("R9 wb perr", mem['h60/4], 32'h2000_0004);
    reg_rd(2'd1, d); check("R9 status perr", d, 32'h06);
    check("R9 irq", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_data_err();
    logic [31:0] d;
    reg_wr(2'd1, 32'h1F);
    put_desc('h70, 32'h8000_0002, 32'h300, 32'h3);
    clear_cap();
    reg_wr(2'd2, 32'h70);
    reg_wr(2'd0, (32'h1 << 31) | (32'h1 << 29) | (32'h1 << 17));
    wait_idle("R10");
    check("R10 no words", ncap, 0);
    check("R10 wb derr", mem['h70/4], 32'h4000_0002);
    reg_rd(2'd1, d); check("R10 status derr", d, 32'h0A);
    check("R10 irq", {31'd0, irq}, 32'd1);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = (i >= 64 && i < 192) ? 32'hA500_0000 + i : 32'h0;
    clear_cap();
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame();
    t_continue_zero();
    t_decrement();
    t_proto_err();
    t_data_err();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule